// File: doc/BRIEF.md
# Floppy Controller Host Register Port

This block is the processor side of a floppy disk controller. The processor sees two locations selected by a one-bit address: a read-only status byte and a single data port. Through the data port it writes a command byte and the parameter bytes that command needs. It then reads back the status bytes the command produced. The block steps through the command, execution and result phases. After every accepted data access it holds the ready bit low for a programmed number of cycles, which models the settling time of the handshake. The status byte also shows the per-drive seek flags and a controller-busy flag.

The disk side is reduced to two interfaces. The opcode and the collected arguments are offered to an execution engine while the block is in its execution phase. The engine returns its result bytes over a valid/ready stream. A byte is taken on every cycle where both `res_valid` and `res_ready` are high. A producer that sees `res_ready` low must hold `res_valid`, `res_data` and `res_last` steady until the byte is taken. `res_ready` is high only during execution, and only while the result store has room. The byte marked with `res_last` ends execution. The producer must mark a byte as last no later than the `RES_DEPTH`-th byte.

Top module: `fdc_host_port`

## Requirements
- R1: A read with `addr`=0 returns the status byte, laid out as {ready bit 7, direction bit 6, execution bit 5, busy bit 4, drive_seek[3:0]}. A read with `addr`=1 returns the result byte at the head of the store, or 0 when the store is empty. A write with `addr`=0 changes nothing.
- R2: After reset the status byte reads 0x80 with `drive_seek`=0, and `res_ready` is low.
- R3: The low five bits of the first command byte select an entry in the opcode table. The table gives the number of argument bytes for each valid opcode: 0x03 takes 2, 0x04 takes 1, 0x05 takes 8, 0x06 takes 8, 0x07 takes 1, 0x08 takes 0, 0x0A takes 1 and 0x0F takes 2. Once the last argument byte is written, the block enters execution. In execution the status byte shows execution=1, busy=1 and ready=0, `exec_active` is 1, `cmd_op` holds the opcode and `cmd_args` holds argument i in bits [8i+7:8i].
- R4: When the first byte carries any other opcode, the block goes straight to the result phase. The result phase then returns exactly one byte, `ERR_STATUS` (default 0x80).
- R5: The transfer opcodes 0x05 and 0x06 are rejected when any `drive_seek` bit is set, with the same error result as R4. Other opcodes are still accepted while drives are seeking.
- R6: After each accepted data-port write or read, and on the byte that ends execution, the ready bit reads 0 for exactly `SETTLE` cycles.
- R7: The direction bit is 0 while command and argument bytes are expected, and 1 during the result phase.
- R8: `res_ready` is high only during execution and only while the store is not full. `res_last` on an accepted byte ends execution.
- R9: Each accepted data read returns the next result byte, in the order the bytes were accepted. The read of the final byte returns the block to the command phase.
- R10: The busy bit rises with the first accepted command byte. It stays high until `SETTLE` cycles after the final result read.
- R11: Status reads have no side effects. A data-port access is ignored when the ready bit is 0 or when the access goes against the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 0 selects status, 1 selects data port |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| drive_seek | input | 4 | Per-drive seek-in-progress flags |
| cmd_op | output | 5 | Opcode of the current command |
| cmd_args | output | 8*MAX_ARGS | Collected argument bytes |
| exec_active | output | 1 | High during the execution phase |
| res_valid | input | 1 | Result byte valid |
| res_data | input | 8 | Result byte |
| res_last | input | 1 | Marks the final result byte |
| res_ready | output | 1 | Result byte accepted when high with res_valid |

## Verification
The assertions assume that the result producer marks a byte as last before the store overflows. They also assume that the processor never raises both strobes in the same cycle, and that `MAX_ARGS` is at least the largest argument count in the table. The stimulus meets each of these assumptions. Every opcode sends between one and four result bytes with `res_last` on the final one, and the strobes are issued one at a time from tasks. Deliberate violations are limited to accesses that the block must ignore: status-address writes, data writes during execution, and data reads in the command phase.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PARAM  = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RESULT = 2'd3
  } phase_t;

  typedef struct packed {
    logic       valid;
    logic       is_xfer;
    logic [3:0] nargs;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [4:0] op);
    op_info_t r;
    r = '{valid: 1'b1, is_xfer: 1'b0, nargs: 4'd0};
    case (op)
      5'h03: r.nargs = 4'd2;
      5'h04: r.nargs = 4'd1;
      5'h05: begin r.nargs = 4'd8; r.is_xfer = 1'b1; end
      5'h06: begin r.nargs = 4'd8; r.is_xfer = 1'b1; end
      5'h07: r.nargs = 4'd1;
      5'h08: r.nargs = 4'd0;
      5'h0A: r.nargs = 4'd1;
      5'h0F: r.nargs = 4'd2;
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fdc_settle_timer.sv
module fdc_settle_timer #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic idle
);

  generate
    if (SETTLE == 0) begin : g_none
      assign idle = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(SETTLE + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= CW'(SETTLE);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
      end

      assign idle = (cnt_q == '0);

      // R6
      countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    end
  endgenerate

endmodule

// File: rtl/fdc_arg_capture.sv
module fdc_arg_capture #(
  parameter int MAX_ARGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wen,
  input  logic [7:0]            wdata,
  output logic [$clog2(MAX_ARGS+1)-1:0] count,
  output logic [MAX_ARGS*8-1:0] args
);

  localparam int AW = $clog2(MAX_ARGS + 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (wen)  cnt_q <= cnt_q + AW'(1);
  end

  assign count = cnt_q;

  genvar g;
  generate
    for (g = 0; g < MAX_ARGS; g++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          slot_q <= '0;
        else if (wen && cnt_q == AW'(g))     slot_q <= wdata;
      end
      assign args[g*8 +: 8] = slot_q;
    end
  endgenerate

  // R3
  arg_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> (32'(cnt_q) < MAX_ARGS));

endmodule

// File: rtl/fdc_result_stack.sv
module fdc_result_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic         last
);

  localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign last  = (cnt_q == CW'(1));
  assign head  = empty ? '0 : mem[rd_ptr];

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/fdc_host_port.sv
module fdc_host_port
  import fdc_hs_pkg::*;
#(
  parameter int         SETTLE     = 3,
  parameter int         RES_DEPTH  = 4,
  parameter int         MAX_ARGS   = 8,
  parameter logic [7:0] ERR_STATUS = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr,
  input  logic                  rd_stb,
  input  logic                  wr_stb,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic [3:0]            drive_seek,
  output logic [4:0]            cmd_op,
  output logic [MAX_ARGS*8-1:0] cmd_args,
  output logic                  exec_active,
  input  logic                  res_valid,
  input  logic [7:0]            res_data,
  input  logic                  res_last,
  output logic                  res_ready
);

  localparam int AW = $clog2(MAX_ARGS + 1);

  phase_t     phase_q;
  logic [4:0] op_q;
  logic [3:0] nargs_q;

  logic       settle_idle;
  logic       rqm, dio, exm, cb;
  logic [7:0] status;

  logic       data_wr, data_rd;
  logic       idle_wr, arg_wen, args_done, err_load;
  logic       res_acc, tmr_load;
  logic [AW-1:0] arg_cnt;
  op_info_t   info;
  logic       first_bad;

  logic       stk_push, stk_full, stk_empty, stk_last;
  logic [7:0] stk_head, push_byte;

  // handshake bits
  assign rqm    = settle_idle && (phase_q != PH_EXEC);
  assign dio    = (phase_q == PH_RESULT);
  assign exm    = (phase_q == PH_EXEC);
  assign cb     = (phase_q != PH_IDLE) || !settle_idle;
  assign status = {rqm, dio, exm, cb, drive_seek};
  assign rdata  = addr ? stk_head : status;

  // accepted data-port accesses
  assign data_wr = wr_stb && !rd_stb && addr && rqm && !dio;
  assign data_rd = rd_stb && !wr_stb && addr && rqm && dio;

  assign info      = decode_op(wdata[4:0]);
  assign first_bad = !info.valid || (info.is_xfer && (|drive_seek));
  assign idle_wr   = (phase_q == PH_IDLE) && data_wr;
  assign arg_wen   = (phase_q == PH_PARAM) && data_wr;
  assign args_done = arg_wen && ((32'(arg_cnt) + 1) == 32'(nargs_q));
  assign err_load  = idle_wr && first_bad;

  assign res_ready = (phase_q == PH_EXEC) && !stk_full;
  assign res_acc   = res_valid && res_ready;
  assign stk_push  = res_acc || err_load;
  assign push_byte = err_load ? ERR_STATUS : res_data;
  assign tmr_load  = data_wr || data_rd || (res_acc && res_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= '0;
      nargs_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (data_wr) begin
          op_q    <= wdata[4:0];
          nargs_q <= info.nargs;
          if (first_bad)               phase_q <= PH_RESULT;
          else if (info.nargs == 4'd0) phase_q <= PH_EXEC;
          else                         phase_q <= PH_PARAM;
        end
        PH_PARAM:  if (args_done)             phase_q <= PH_EXEC;
        PH_EXEC:   if (res_acc && res_last)   phase_q <= PH_RESULT;
        PH_RESULT: if (data_rd && stk_last)   phase_q <= PH_IDLE;
        default:                              phase_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_op      = op_q;
  assign exec_active = exm;

  fdc_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .idle  (settle_idle)
  );

  fdc_arg_capture #(.MAX_ARGS(MAX_ARGS)) u_args (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle_wr),
    .wen   (arg_wen),
    .wdata (wdata),
    .count (arg_cnt),
    .args  (cmd_args)
  );

  fdc_result_stack #(.DEPTH(RES_DEPTH), .W(8)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .push_data (push_byte),
    .pop       (data_rd),
    .head      (stk_head),
    .full      (stk_full),
    .empty     (stk_empty),
    .last      (stk_last)
  );

  // R3
  exec_entry_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exm) |-> cb);

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cb) |-> (rqm && !dio && stk_empty));

  // R9
  result_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESULT) |-> !stk_empty);

  generate
    if (SETTLE > 0) begin : g_settle_chk
      // R6
      ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |=> !rqm);
      // R10
      busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && stk_last) |=> cb);
    end
  endgenerate

endmodule

// File: tb/tb_fdc_host_port.sv
module tb_fdc_host_port;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int DEPTH      = 4;
  localparam int MAXA       = 8;
  localparam logic [7:0] ERRB = 8'h80;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] drive_seek = '0;
  logic [4:0] cmd_op;
  logic [MAXA*8-1:0] cmd_args;
  logic exec_active;
  logic res_valid = 1'b0, res_last = 1'b0;
  logic [7:0] res_data = '0;
  logic res_ready;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_host_port #(.SETTLE(SETTLE), .RES_DEPTH(DEPTH), .MAX_ARGS(MAXA),
                  .ERR_STATUS(ERRB)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .drive_seek(drive_seek), .cmd_op(cmd_op),
    .cmd_args(cmd_args), .exec_active(exec_active), .res_valid(res_valid),
    .res_data(res_data), .res_last(res_last), .res_ready(res_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int tb_nargs(input int op);
    case (op)
      3: return 2;  4: return 1;  5: return 8;  6: return 8;
      7: return 1;  8: return 0;  10: return 1; 15: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic wr_port(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; addr = 1'b0;
  endtask

  task automatic rd_port(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_stb = 1'b0; addr = 1'b0;
  endtask

  task automatic status_now(output logic [7:0] s);
    addr = 1'b0;
    #1 s = rdata;
  endtask

  task automatic wait_bit(input int pos, input logic val, output int n);
    logic [7:0] s;
    n = 0;
    status_now(s);
    while (s[pos] !== val && n < 1000) begin
      @(negedge clk);
      n++;
      status_now(s);
    end
  endtask

  task automatic push_res(input logic [7:0] d, input logic l);
    @(negedge clk);
    res_valid = 1'b1; res_data = d; res_last = l;
    #1 chk(res_ready === 1'b1, "R8 res_ready in execution", int'(res_ready), 1);
    @(negedge clk);
    res_valid = 1'b0; res_last = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] first, input int nres, input logic [3:0] seek);
    int op, na, n, cnt;
    bit err;
    logic [7:0] s, d, exp_b;
    op = int'(first[4:0]);
    na = tb_nargs(op);
    err = (na < 0) || ((op == 5 || op == 6) && seek != 4'd0);
    drive_seek = seek;
    status_now(s);
    chk(s == {4'b1000, seek}, "R1 idle status", int'(s), int'({4'b1000, seek}));
    wr_port(1'b1, first);
    status_now(s);
    chk(s[4] === 1'b1, "R10 busy after first byte", int'(s[4]), 1);
    if (!err) begin
      for (int i = 0; i < na; i++) begin
        wait_bit(7, 1'b1, n);
        chk(n == SETTLE, "R6 settle after write", n, SETTLE);
        status_now(s);
        chk(s[6] === 1'b0, "R7 direction in command phase", int'(s[6]), 0);
        if (i == 0) begin
          rd_port(1'b1, d);
          status_now(s);
          chk(s[7] === 1'b1, "R11 wrong-direction read ignored", int'(s[7]), 1);
        end
        wr_port(1'b1, 8'(op * 16 + i));
      end
      status_now(s);
      chk(s == {4'b0011, seek}, "R3 execution status", int'(s), int'({4'b0011, seek}));
      chk(exec_active === 1'b1 && int'(cmd_op) == op, "R3 exec_active/cmd_op",
          int'(cmd_op), op);
      if (na > 0)
        chk(cmd_args[8*(na-1) +: 8] == 8'(op * 16 + na - 1), "R3 last argument",
            int'(cmd_args[8*(na-1) +: 8]), (op * 16 + na - 1) & 255);
      wr_port(1'b1, 8'hFF);
      status_now(s);
      chk(s == {4'b0011, seek}, "R11 write during execution ignored", int'(s),
          int'({4'b0011, seek}));
      for (int k = 0; k < nres; k++)
        push_res(8'(op * 7 + k * 53), k == nres - 1);
      cnt = nres;
    end else begin
      cnt = 1;
    end
    #1 chk(res_ready === 1'b0, "R8 res_ready low in result phase", int'(res_ready), 0);
    wait_bit(7, 1'b1, n);
    chk(n == SETTLE, "R6 settle on entry to result phase", n, SETTLE);
    for (int k = 0; k < cnt; k++) begin
      status_now(s);
      chk(s[6] === 1'b1 && s[5] === 1'b0, "R7 direction in result phase", int'(s), 8'hD0);
      rd_port(1'b0, s);
      rd_port(1'b0, s);
      exp_b = err ? ERRB : 8'(op * 7 + k * 53);
      rd_port(1'b1, d);
      chk(d == exp_b, err ? "R4 R5 error byte" : "R9 result byte order", int'(d),
          int'(exp_b));
      if (k < cnt - 1) begin
        wait_bit(7, 1'b1, n);
        chk(n == SETTLE, "R6 settle after read", n, SETTLE);
      end
    end
    status_now(s);
    chk(s[4] === 1'b1, "R10 busy holds after final read", int'(s[4]), 1);
    wait_bit(4, 1'b0, n);
    chk(n == SETTLE, "R10 busy clears after settle", n, SETTLE);
    status_now(s);
    chk(s == {4'b1000, seek}, "R9 back to command phase", int'(s), int'({4'b1000, seek}));
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    status_now(s);
    chk(s == 8'h80, "R2 reset status", int'(s), 8'h80);
    chk(res_ready === 1'b0, "R2 res_ready after reset", int'(res_ready), 0);

    wr_port(1'b0, 8'h06);
    status_now(s);
    chk(s == 8'h80, "R1 status-address write ignored", int'(s), 8'h80);
    @(negedge clk);
    status_now(s);
    chk(s == 8'h80, "R1 no settle after status write", int'(s), 8'h80);

    for (int op = 0; op < 32; op++)
      run_cmd(8'(op | ((op & 1) ? 8'hA0 : 8'h40)), (op % DEPTH) + 1, 4'd0);

    for (int m = 1; m < 16; m++)
      run_cmd((m & 1) ? 8'h05 : 8'h06, 2, 4'(m));
    run_cmd(8'h0F, 3, 4'b0011);
    run_cmd(8'h08, 4, 4'b1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule